// File: doc/BRIEF.md
# Bi-mode branch direction predictor

This block predicts whether a conditional branch is taken. It has two direction tables and one choice table. One direction table starts biased toward taken and the other toward not-taken. The choice table is indexed by the branch address alone, and the counter it returns decides which direction table gives the answer. Each direction table is indexed by a hash of the address combined with a global history of resolved outcomes. Taken branches then mostly train the taken-leaning table and not-taken branches the other, so branches that share an entry disturb each other less.

Every cycle the block takes an address on the predict port. In the same cycle, with no register on the path, it returns the prediction and the two table indices it used. Once the branch resolves, the pipeline sends those indices back on the update port together with the real outcome. The block then trains the same entries and shifts the outcome into the history register. A prediction and an update can arrive in the same cycle.

Top module: `bimode_predictor`

## Requirements
- R1: After a synchronous active-low reset the history register is zero. The not-taken-leaning table (side 0) holds weakly-not-taken (binary 01 for 2-bit counters). The taken-leaning table (side 1) holds weakly-taken (10). The choice table holds weakly-not-taken, so it selects side 0. Every prediction made before the first update is therefore not-taken.
- R2: The choice index is the address XOR-folded into CHO_W bits: address bit i goes to index bit i mod CHO_W. The direction index is the address folded the same way into IDX_W bits, then XORed with the history register. Both indices are driven on the prediction outputs.
- R3: When the most significant bit of the choice counter is 1, side 1 is selected; otherwise side 0. The prediction is the most significant bit of the selected side's counter at the direction index. It appears combinationally in the same cycle as the address.
- R4: An update trains only the side that the choice counter at the returned choice index selects when the update arrives. The other side's entry keeps its value.
- R5: Every counter is CNT_W bits wide and saturates. A taken outcome adds one unless the counter is all ones. A not-taken outcome subtracts one unless it is zero. It never wraps.
- R6: The choice counter moves toward the outcome, with one exception. It is left alone when its own most significant bit disagrees with the outcome but the selected direction counter's most significant bit agrees with it.
- R7: Each update shifts the outcome into bit 0 of the history register, and the older bits move up one place. Without an update the history register holds its value.
- R8: When a prediction and an update fall in the same cycle, the prediction sees the state from before that update. The update takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pred_pc | input | ADDR_W | Branch address to predict |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_side | output | 1 | Side chosen for this prediction |
| pred_dir_idx | output | IDX_W | Direction index used for this prediction |
| pred_cho_idx | output | CHO_W | Choice index used for this prediction |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_taken | input | 1 | Resolved outcome, 1 = taken |
| upd_dir_idx | input | IDX_W | Direction index returned from prediction time |
| upd_cho_idx | input | CHO_W | Choice index returned from prediction time |

## Verification
A lookup and a training write can fall in the same cycle, and both can hit the same counters. The bench provokes this in two ways. In one phase it predicts an address while updating the entries that same address maps to. In another it lets a random trace overlap updates with new lookups on every cycle. The reference model keeps its state from before the edge until after the comparison, so the same-cycle prediction is judged against the old counters and the next cycle's prediction against the trained ones.

// File: rtl/bimode_pkg.sv
// Package: shared types for the bi-mode predictor.
// Assumes: side 0 is the not-taken-leaning table, side 1 the taken-leaning one.
package bimode_pkg;
    typedef enum logic {
        SIDE_NT = 1'b0,
        SIDE_T  = 1'b1
    } side_e;

    localparam int unsigned NUM_SIDES = 2;
endpackage

// File: rtl/bimode_hash.sv
// Module: bimode_hash
// Folds a branch address into the choice index and, with the global
// history mixed in, into the direction index.
// Assumes: hist width equals IDX_W; purely combinational.
module bimode_hash #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned IDX_W  = 8,
    parameter int unsigned CHO_W  = 8
) (
    input  logic [ADDR_W-1:0] pc,
    input  logic [IDX_W-1:0]  hist,
    output logic [IDX_W-1:0]  dir_idx,
    output logic [CHO_W-1:0]  cho_idx
);
    logic [IDX_W-1:0] fold_dir;
    logic [CHO_W-1:0] fold_cho;

    // Purpose: XOR-fold every address bit into both index widths.
    always_comb begin
        fold_dir = '0;
        fold_cho = '0;
        for (int i = 0; i < int'(ADDR_W); i++) begin
            fold_dir[i % IDX_W] = fold_dir[i % IDX_W] ^ pc[i];
            fold_cho[i % CHO_W] = fold_cho[i % CHO_W] ^ pc[i];
        end
    end

    assign dir_idx = fold_dir ^ hist;
    assign cho_idx = fold_cho;
endmodule

// File: rtl/bimode_ctr_bank.sv
// Module: bimode_ctr_bank
// A bank of saturating counters with one lookup port, one training-side
// read port and one write that steps the training entry by one.
// Assumes: synchronous active-low reset loads INIT_VAL into every entry.
module bimode_ctr_bank #(
    parameter int unsigned      IDX_W    = 8,
    parameter int unsigned      CNT_W    = 2,
    parameter logic [CNT_W-1:0] INIT_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_msb,
    input  logic [IDX_W-1:0] trn_idx,
    output logic             trn_msb,
    input  logic             trn_en,
    input  logic             trn_up
);
    localparam int unsigned      DEPTH   = 1 << IDX_W;
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_MIN = '0;

    logic [CNT_W-1:0] ctr_q [DEPTH];
    logic [CNT_W-1:0] trn_cur;

    assign rd_msb  = ctr_q[rd_idx][CNT_W-1];
    assign trn_cur = ctr_q[trn_idx];
    assign trn_msb = trn_cur[CNT_W-1];

    // Purpose: reset all entries, or step the training entry with saturation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(DEPTH); i++) begin
                ctr_q[i] <= INIT_VAL;
            end
        end else if (trn_en) begin
            if (trn_up && (trn_cur != CNT_MAX)) begin
                ctr_q[trn_idx] <= trn_cur + 1'b1;
            end else if (!trn_up && (trn_cur != CNT_MIN)) begin
                ctr_q[trn_idx] <= trn_cur - 1'b1;
            end
        end
    end
endmodule

// File: rtl/bimode_predictor.sv
// Module: bimode_predictor (top)
// Direction predictor with two biased direction tables, picked per lookup
// by an address-indexed choice table. Lookup is combinational; training
// and the history shift happen at the clock edge of an update.
// Assumes: IDX_W >= 2, CNT_W >= 2; updates carry the indices that were
// produced at prediction time.
module bimode_predictor #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned IDX_W  = 8,
    parameter int unsigned CHO_W  = 8,
    parameter int unsigned CNT_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] pred_pc,
    output logic              pred_taken,
    output logic              pred_side,
    output logic [IDX_W-1:0]  pred_dir_idx,
    output logic [CHO_W-1:0]  pred_cho_idx,
    input  logic              upd_valid,
    input  logic              upd_taken,
    input  logic [IDX_W-1:0]  upd_dir_idx,
    input  logic [CHO_W-1:0]  upd_cho_idx
);
    import bimode_pkg::*;

    localparam logic [CNT_W-1:0] WEAK_NT = {1'b0, {(CNT_W-1){1'b1}}};
    localparam logic [CNT_W-1:0] WEAK_T  = {1'b1, {(CNT_W-1){1'b0}}};

    logic [IDX_W-1:0]     ghr_q;
    logic [NUM_SIDES-1:0] look_msb;
    logic [NUM_SIDES-1:0] trn_msb;
    logic [NUM_SIDES-1:0] dir_wr;
    logic                 cho_look_msb;
    logic                 cho_trn_msb;
    logic                 cho_wr;
    side_e                look_side;
    side_e                trn_side;
    logic                 trn_dir_pred;

    bimode_hash #(
        .ADDR_W (ADDR_W),
        .IDX_W  (IDX_W),
        .CHO_W  (CHO_W)
    ) u_hash (
        .pc      (pred_pc),
        .hist    (ghr_q),
        .dir_idx (pred_dir_idx),
        .cho_idx (pred_cho_idx)
    );

    bimode_ctr_bank #(
        .IDX_W    (CHO_W),
        .CNT_W    (CNT_W),
        .INIT_VAL (WEAK_NT)
    ) u_choice (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (pred_cho_idx),
        .rd_msb  (cho_look_msb),
        .trn_idx (upd_cho_idx),
        .trn_msb (cho_trn_msb),
        .trn_en  (cho_wr),
        .trn_up  (upd_taken)
    );

    // One direction bank per side; side 1 starts weakly taken.
    for (genvar g = 0; g < int'(NUM_SIDES); g++) begin : g_side
        bimode_ctr_bank #(
            .IDX_W    (IDX_W),
            .CNT_W    (CNT_W),
            .INIT_VAL ((g == 1) ? WEAK_T : WEAK_NT)
        ) u_dir (
            .clk     (clk),
            .rst_n   (rst_n),
            .rd_idx  (pred_dir_idx),
            .rd_msb  (look_msb[g]),
            .trn_idx (upd_dir_idx),
            .trn_msb (trn_msb[g]),
            .trn_en  (dir_wr[g]),
            .trn_up  (upd_taken)
        );
        assign dir_wr[g] = upd_valid && (trn_side == side_e'(g));
    end

    assign look_side  = side_e'(cho_look_msb);
    assign pred_side  = look_side;
    assign pred_taken = look_msb[look_side];

    assign trn_side     = side_e'(cho_trn_msb);
    assign trn_dir_pred = trn_msb[trn_side];

    // Purpose: leave the chooser alone when it was wrong but its pick was right.
    always_comb begin
        cho_wr = upd_valid;
        if ((cho_trn_msb != upd_taken) && (trn_dir_pred == upd_taken)) begin
            cho_wr = 1'b0;
        end
    end

    // Purpose: global history register, newest outcome in bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ghr_q <= '0;
        end else if (upd_valid) begin
            ghr_q <= {ghr_q[IDX_W-2:0], upd_taken};
        end
    end
endmodule

// File: rtl/bimode_predictor_chk.sv
// Module: bimode_predictor_chk
// Checker bound to bimode_predictor: history behaviour, which banks take
// a write, and that the prediction is steady while nothing changes.
// Assumes: synchronous active-low reset; armed one cycle after reset ends.
module bimode_predictor_chk #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned IDX_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] pred_pc,
    input logic              pred_taken,
    input logic              upd_valid,
    input logic              upd_taken,
    input logic [IDX_W-1:0]  ghr,
    input logic [1:0]        dir_wr,
    input logic              cho_wr
);
    logic armed_q;

    // Purpose: mark the first cycle whose predecessor was out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    a_r7_hist_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && upd_valid) |=> (ghr == {$past(ghr[IDX_W-2:0]), $past(upd_taken)}));

    a_r7_hist_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !upd_valid) |=> $stable(ghr));

    a_r4_one_bank: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |-> ($countones(dir_wr) == 1));

    a_r4_no_bank_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |-> (dir_wr == 2'b00));

    a_r6_cho_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |-> !cho_wr);

    a_r8_pred_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !$past(upd_valid) && $stable(pred_pc)) |-> $stable(pred_taken));
endmodule

bind bimode_predictor bimode_predictor_chk #(
    .ADDR_W (ADDR_W),
    .IDX_W  (IDX_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .pred_pc    (pred_pc),
    .pred_taken (pred_taken),
    .upd_valid  (upd_valid),
    .upd_taken  (upd_taken),
    .ghr        (ghr_q),
    .dir_wr     (dir_wr),
    .cho_wr     (cho_wr)
);

// File: tb/bimode_predictor_tb_top.sv
// Bench: behavioural reference model compared on every clock.
module bimode_predictor_tb_top;
    localparam int ADDR_W = 16;
    localparam int IDX_W  = 8;
    localparam int CHO_W  = 8;
    localparam int CNT_W  = 2;
    localparam int DIR_N  = 1 << IDX_W;
    localparam int CHO_N  = 1 << CHO_W;
    localparam int HALF   = 1 << (CNT_W - 1);
    localparam int MAXC   = (1 << CNT_W) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] pred_pc = '0;
    logic              pred_taken;
    logic              pred_side;
    logic [IDX_W-1:0]  pred_dir_idx;
    logic [CHO_W-1:0]  pred_cho_idx;
    logic              upd_valid = 1'b0;
    logic              upd_taken = 1'b0;
    logic [IDX_W-1:0]  upd_dir_idx = '0;
    logic [CHO_W-1:0]  upd_cho_idx = '0;

    always #5 clk = ~clk;

    bimode_predictor #(
        .ADDR_W (ADDR_W), .IDX_W (IDX_W), .CHO_W (CHO_W), .CNT_W (CNT_W)
    ) dut_i (
        .clk (clk), .rst_n (rst_n),
        .pred_pc (pred_pc), .pred_taken (pred_taken), .pred_side (pred_side),
        .pred_dir_idx (pred_dir_idx), .pred_cho_idx (pred_cho_idx),
        .upd_valid (upd_valid), .upd_taken (upd_taken),
        .upd_dir_idx (upd_dir_idx), .upd_cho_idx (upd_cho_idx)
    );

    // Reference state
    int m_dir [2][DIR_N];
    int m_cho [CHO_N];
    int m_hist;
    int n_vec = 0;
    int n_bad = 0;
    int q_di [$];
    int q_ci [$];
    int q_pc [$];

    function automatic int fold(input int pc, input int w);
        int r = 0;
        for (int i = 0; i < ADDR_W; i++) r = r ^ (((pc >> i) & 1) << (i % w));
        return r;
    endfunction

    function automatic int exp_di(input int pc);
        return fold(pc, IDX_W) ^ m_hist;
    endfunction

    function automatic int sat(input int v, input bit up);
        if (up) return (v == MAXC) ? v : v + 1;
        return (v == 0) ? v : v - 1;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < DIR_N; i++) begin
            m_dir[0][i] = HALF - 1;
            m_dir[1][i] = HALF;
        end
        for (int i = 0; i < CHO_N; i++) m_cho[i] = HALF - 1;
        m_hist = 0;
    endtask

    task automatic model_update(input bit t, input int di, input int ci);
        int s;
        bit p;
        s = (m_cho[ci] >= HALF) ? 1 : 0;
        p = (m_dir[s][di] >= HALF);
        m_dir[s][di] = sat(m_dir[s][di], t);
        if (!((s != int'(t)) && (p == t))) m_cho[ci] = sat(m_cho[ci], t);
        m_hist = ((m_hist << 1) | int'(t)) & (DIR_N - 1);
    endtask

    task automatic report(input string tag, input string what, input int act, input int exp);
        n_bad++;
        $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
    endtask

    // One cycle: drive, compare the combinational lookup, then advance the model.
    task automatic step(input int pc, input bit uv, input bit ut, input int udi,
                        input int uci, input string tag);
        int edi, eci, es, et;
        @(negedge clk);
        pred_pc     = ADDR_W'(pc);
        upd_valid   = uv;
        upd_taken   = ut;
        upd_dir_idx = IDX_W'(udi);
        upd_cho_idx = CHO_W'(uci);
        #4;
        edi = exp_di(pc);
        eci = fold(pc, CHO_W);
        es  = (m_cho[eci] >= HALF) ? 1 : 0;
        et  = (m_dir[es][edi] >= HALF) ? 1 : 0;
        n_vec++;
        if (int'(pred_dir_idx) != edi) report("R2", "dir_idx", int'(pred_dir_idx), edi);
        if (int'(pred_cho_idx) != eci) report("R2", "cho_idx", int'(pred_cho_idx), eci);
        if (int'(pred_side) != es)     report(tag, "side", int'(pred_side), es);
        if (int'(pred_taken) != et)    report(tag, "taken", int'(pred_taken), et);
        q_di.push_back(edi);
        q_ci.push_back(eci);
        q_pc.push_back(pc);
        @(posedge clk);
        if (uv) model_update(ut, udi, uci);
    endtask

    task automatic run_all();
        int pc_a, di, ci, pc, bias;
        bit t;
        // R1: reset state, every lookup predicts not-taken
        rst_n = 1'b0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 6; i++) begin
            step(i * 16'h0a37 + 5, 1'b0, 1'b0, 0, 0, "R1");
            n_vec++;
            if (pred_taken !== 1'b0) report("R1", "reset_pred", int'(pred_taken), 0);
        end
        // R5: hammer one address taken until history saturates, then flip
        pc_a = 16'h4c21;
        q_di.delete(); q_ci.delete(); q_pc.delete();
        for (int i = 0; i < 14; i++) begin
            di = exp_di(pc_a);
            ci = fold(pc_a, CHO_W);
            step(pc_a, 1'b0, 1'b0, 0, 0, "R5");
            step(pc_a, 1'b1, 1'b1, di, ci, "R5");
        end
        for (int i = 0; i < 3; i++) begin
            di = exp_di(pc_a);
            ci = fold(pc_a, CHO_W);
            step(pc_a, 1'b1, 1'b0, di, ci, "R5");
            step(pc_a, 1'b0, 1'b0, 0, 0, "R5");
        end
        // R8: update the very entries being looked up in the same cycle
        for (int i = 0; i < 24; i++) begin
            pc = 16'h1200 + (i % 3) * 16'h0111;
            step(pc, 1'b1, (i % 4) != 0, exp_di(pc), fold(pc, CHO_W), "R8");
        end
        // R4/R6/R7: opposing biases on entries hit through both sides
        for (int i = 0; i < 40; i++) begin
            pc = (i % 2) ? 16'h00f0 : 16'h0f00;
            step(pc, 1'b1, (i % 2) == 1, exp_di(pc), fold(pc, CHO_W), "R6");
            step(pc, 1'b0, 1'b0, 0, 0, "R7");
        end
        // R3: random trace with delayed updates carrying returned indices
        q_di.delete(); q_ci.delete(); q_pc.delete();
        for (int i = 0; i < 4000; i++) begin
            pc = ((i * 7) % 16) * 16'h1357 + 16'h0042;
            if ((q_di.size() > 3) && (($urandom % 100) < 75)) begin
                di = q_di.pop_front();
                ci = q_ci.pop_front();
                bias = q_pc.pop_front();
                t = (($urandom % 100) < (((bias >> 4) & 1) ? 88 : 12));
                step(pc, 1'b1, t, di, ci, "R3");
            end else begin
                step(pc, 1'b0, 1'b0, 0, 0, "R4");
            end
        end
    endtask

    initial begin
        bit timed_out = 1'b0;
        fork
            run_all();
            begin
                #(200000 * 10);
                timed_out = 1'b1;
            end
        join_any
        disable fork;
        if (timed_out) begin
            n_bad++;
            $display("FAIL watchdog actual=running expected=done");
        end
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule